// File: doc/BRIEF.md
# Resource-Tag and Keyword Field Locator

This block searches a byte image of product-identification data kept in a local RAM. The image is a chain of variable-length records. Each record begins with a short header that gives its own length, so the search jumps from header to header instead of reading every byte. The RAM is loaded through a plain byte write port. A search is launched with a one-cycle start pulse.

There are two search modes. In tag mode the walk begins at offset 0 and visits large resource records only. A large record is one whose first byte has bit 7 set, and its header is 3 bytes: the tag byte, then a 16-bit body length with the low byte first. The walk stops at the first byte that is not a large tag. In keyword mode the walk covers a caller-given region (start offset and length) made of 3-byte field headers, each holding two keyword characters followed by a one-byte body length. In both modes the block returns the offset of the matching header, or a not-found result, together with a one-cycle done pulse.

The RAM has one cycle of read latency, and the walker fetches the header bytes one after another. Each visited header therefore costs four cycles.

Top module: `vpd_locator`

## Requirements
- R1: With mode_i=0 (tag mode), the walk starts at offset 0 and compares the whole 8-bit byte at each visited header with tag_i. On a match it reports found_o=1 and offset_o equal to that header's offset.
- R2: In tag mode a non-matching large header at offset p moves the walk to p + 3 + L. L is the 16-bit length made of the byte at p+1 (low) and the byte at p+2 (high).
- R3: In tag mode a visited byte with bit 7 clear ends the search with found_o=0, even when that byte equals tag_i.
- R4: In tag mode a header at offset p is examined only if p + 3 <= buf_len_i. Otherwise the search ends with found_o=0. The values of rgn_start_i and rgn_len_i have no effect in tag mode.
- R5: With mode_i=1 (keyword mode), the walk starts at rgn_start_i. A field matches only when its first byte equals key0_i and its second byte equals key1_i. The block then reports found_o=1 with that field's offset.
- R6: In keyword mode a non-matching field at offset p moves the walk to p + 3 + D. D is the byte at p+2.
- R7: In keyword mode a field at offset p is examined only if p + 3 <= rgn_start_i + rgn_len_i. Otherwise the search ends with found_o=0. buf_len_i has no effect in keyword mode.
- R8: A start_i pulse that arrives while a search is running is ignored. It neither changes that search's result nor produces an extra done pulse.
- R9: done_o is high for exactly one cycle per search. found_o and offset_o change only in that cycle and hold afterwards. After reset, done_o, found_o and offset_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one byte into the image RAM |
| wr_addr_i | input | ADDR_W | RAM write address |
| wr_data_i | input | 8 | RAM write data |
| start_i | input | 1 | Launch a search (taken only when idle) |
| mode_i | input | 1 | 0 = tag search, 1 = keyword search |
| tag_i | input | 8 | Requested tag byte |
| key0_i | input | 8 | First keyword character |
| key1_i | input | 8 | Second keyword character |
| buf_len_i | input | ADDR_W+1 | Valid image length for tag mode |
| rgn_start_i | input | ADDR_W | Keyword region start offset |
| rgn_len_i | input | ADDR_W+1 | Keyword region length |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | Result of the last search |
| offset_o | output | ADDR_W | Offset of the matching header |

## Verification
Tag searches run over a chain whose records have different body lengths. One record carries a nonzero high length byte, and it is placed so that a walker which drops that byte would land on a false match. Boundary runs set buf_len_i exactly at a header's end and one byte short of it, which separates an off-by-one in the fit test from a correct one. Keyword searches use exact, half-matching and swapped character pairs to show that both characters are required and compared in order. They also shrink the region across the last field's end and start in mid-chain. Directed runs then cover a non-large byte that equals the requested tag, and a start pulse issued in the middle of a search.

// File: rtl/vpd_loc_pkg.sv
package vpd_loc_pkg;
  typedef enum logic {MODE_TAG = 1'b0, MODE_KEY = 1'b1} loc_mode_e;
  typedef enum logic [2:0] {ST_IDLE, ST_CHK, ST_H0, ST_H1, ST_H2} walk_st_e;
  localparam int HDR_BYTES = 3;
endpackage

// File: rtl/vpd_buf_ram.sv
module vpd_buf_ram #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
    rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/vpd_walk_fsm.sv
module vpd_walk_fsm
  import vpd_loc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PW     = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [PW-1:0]     start_pos_i,
  input  loc_mode_e         mode_i,
  input  logic [7:0]        tag_i,
  input  logic [7:0]        key0_i,
  input  logic [7:0]        key1_i,
  input  logic [PW-1:0]     limit_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic [ADDR_W-1:0] offset_o
);
  walk_st_e          st_q;
  logic [PW-1:0]     pos_q;
  logic [7:0]        b0_q;
  logic [ADDR_W-1:0] rd_ofs;

  // header byte index fetched in each state; data returns one state later
  always_comb begin
    case (st_q)
      ST_H0:   rd_ofs = ADDR_W'(1);
      ST_H1:   rd_ofs = ADDR_W'(2);
      default: rd_ofs = '0;
    endcase
  end

  assign rd_addr_o = pos_q[ADDR_W-1:0] + rd_ofs;
  assign busy_o    = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pos_q    <= '0;
      b0_q     <= '0;
      done_o   <= 1'b0;
      found_o  <= 1'b0;
      offset_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (go_i) begin
          pos_q <= start_pos_i;
          st_q  <= ST_CHK;
        end
        ST_CHK: begin
          if (pos_q + PW'(HDR_BYTES) <= limit_i) begin
            st_q <= ST_H0;
          end else begin
            st_q    <= ST_IDLE;
            done_o  <= 1'b1;
            found_o <= 1'b0;
          end
        end
        ST_H0: begin
          if (mode_i == MODE_TAG) begin
            if (!rd_data_i[7] || rd_data_i == tag_i) begin
              st_q     <= ST_IDLE;
              done_o   <= 1'b1;
              found_o  <= rd_data_i[7];
              offset_o <= pos_q[ADDR_W-1:0];
            end else begin
              st_q <= ST_H1;
            end
          end else begin
            b0_q <= rd_data_i;
            st_q <= ST_H1;
          end
        end
        ST_H1: begin
          if (mode_i == MODE_TAG) begin
            b0_q <= rd_data_i;  // length low byte
            st_q <= ST_H2;
          end else if (b0_q == key0_i && rd_data_i == key1_i) begin
            st_q     <= ST_IDLE;
            done_o   <= 1'b1;
            found_o  <= 1'b1;
            offset_o <= pos_q[ADDR_W-1:0];
          end else begin
            st_q <= ST_H2;
          end
        end
        ST_H2: begin
          if (mode_i == MODE_TAG)
            pos_q <= pos_q + PW'(HDR_BYTES) + PW'({rd_data_i, b0_q});
          else
            pos_q <= pos_q + PW'(HDR_BYTES) + PW'(rd_data_i);
          st_q <= ST_CHK;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vpd_locator.sv
module vpd_locator
  import vpd_loc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [7:0]        tag_i,
  input  logic [7:0]        key0_i,
  input  logic [7:0]        key1_i,
  input  logic [ADDR_W:0]   buf_len_i,
  input  logic [ADDR_W-1:0] rgn_start_i,
  input  logic [ADDR_W:0]   rgn_len_i,
  output logic              done_o,
  output logic              found_o,
  output logic [ADDR_W-1:0] offset_o
);
  // wide enough for a position plus a 16-bit skip
  localparam int PW = ((ADDR_W > 16) ? ADDR_W : 16) + 2;

  logic              busy;
  logic              go;
  loc_mode_e         mode_q;
  logic [7:0]        tag_q, key0_q, key1_q;
  logic [PW-1:0]     limit_q;
  logic [PW-1:0]     start_pos;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  assign go        = start_i && !busy;
  assign start_pos = mode_i ? PW'(rgn_start_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_TAG;
      tag_q   <= '0;
      key0_q  <= '0;
      key1_q  <= '0;
      limit_q <= '0;
    end else if (go) begin
      mode_q  <= loc_mode_e'(mode_i);
      tag_q   <= tag_i;
      key0_q  <= key0_i;
      key1_q  <= key1_i;
      limit_q <= mode_i ? PW'(rgn_start_i) + PW'(rgn_len_i) : PW'(buf_len_i);
    end
  end

  vpd_buf_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  vpd_walk_fsm #(.ADDR_W(ADDR_W), .PW(PW)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .start_pos_i (start_pos),
    .mode_i      (mode_q),
    .tag_i       (tag_q),
    .key0_i      (key0_q),
    .key1_i      (key1_q),
    .limit_i     (limit_q),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .busy_o      (busy),
    .done_o      (done_o),
    .found_o     (found_o),
    .offset_o    (offset_o)
  );
endmodule

// File: rtl/vpd_locator_chk.sv
module vpd_locator_chk
  import vpd_loc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PW     = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy,
  input logic              done_o,
  input logic              found_o,
  input logic [ADDR_W-1:0] offset_o,
  input loc_mode_e         mode_q,
  input logic [7:0]        tag_q,
  input logic [PW-1:0]     limit_q
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy); // R9

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(found_o) && $stable(offset_o))); // R9

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> ($stable(mode_q) && $stable(tag_q) && $stable(limit_q))); // R8

  AST_TAG_IS_LARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && found_o && mode_q == MODE_TAG) |-> tag_q[7]); // R3

  AST_HDR_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && found_o) |-> (PW'(offset_o) + PW'(HDR_BYTES) <= limit_q)); // R4 R7
endmodule

bind vpd_locator vpd_locator_chk #(.ADDR_W(ADDR_W), .PW(PW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy     (busy),
  .done_o   (done_o),
  .found_o  (found_o),
  .offset_o (offset_o),
  .mode_q   (mode_q),
  .tag_q    (tag_q),
  .limit_q  (limit_q)
);

// File: tb/tb_vpd_locator.sv
module tb_vpd_locator;
  localparam int ADDR_W = 8;

  typedef struct packed {
    logic       mode;
    logic [7:0] tag;
    logic [7:0] k0;
    logic [7:0] k1;
    logic [8:0] blen;
    logic [7:0] rs;
    logic [8:0] rl;
    logic       ef;
    logic [7:0] eo;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h82, 8'h00, 8'h00, 9'd256, 8'd0,   9'd0,  1'b1, 8'd0,   8'd1}, // R1 first
    '{1'b0, 8'h90, 8'h00, 8'h00, 9'd256, 8'd0,   9'd0,  1'b1, 8'd8,   8'd2}, // R2
    '{1'b0, 8'h91, 8'h00, 8'h00, 9'd256, 8'd0,   9'd0,  1'b1, 8'd27,  8'd2}, // R2
    '{1'b0, 8'h84, 8'h50, 8'h4E, 9'd256, 8'd160, 9'd19, 1'b1, 8'd94,  8'd2}, // R2 rgn ignored
    '{1'b0, 8'h85, 8'h00, 8'h00, 9'd256, 8'd0,   9'd0,  1'b0, 8'd0,   8'd2}, // R2 high byte
    '{1'b0, 8'h91, 8'h00, 8'h00, 9'd30,  8'd0,   9'd0,  1'b1, 8'd27,  8'd4}, // R4 exact fit
    '{1'b0, 8'h91, 8'h00, 8'h00, 9'd29,  8'd0,   9'd0,  1'b0, 8'd0,   8'd4}, // R4 one short
    '{1'b0, 8'h90, 8'h00, 8'h00, 9'd11,  8'd0,   9'd0,  1'b1, 8'd8,   8'd4}, // R4
    '{1'b0, 8'h90, 8'h00, 8'h00, 9'd10,  8'd0,   9'd0,  1'b0, 8'd0,   8'd4}, // R4
    '{1'b0, 8'h82, 8'h00, 8'h00, 9'd2,   8'd0,   9'd0,  1'b0, 8'd0,   8'd4}, // R4 tiny
    '{1'b1, 8'h82, 8'h50, 8'h4E, 9'd1,   8'd160, 9'd19, 1'b1, 8'd160, 8'd5}, // R5
    '{1'b1, 8'h00, 8'h45, 8'h43, 9'd1,   8'd160, 9'd19, 1'b1, 8'd167, 8'd6}, // R6
    '{1'b1, 8'h00, 8'h53, 8'h4E, 9'd1,   8'd160, 9'd19, 1'b1, 8'd172, 8'd6}, // R6
    '{1'b1, 8'h00, 8'h56, 8'h31, 9'd1,   8'd160, 9'd19, 1'b1, 8'd175, 8'd6}, // R6
    '{1'b1, 8'h00, 8'h5A, 8'h5A, 9'd1,   8'd160, 9'd19, 1'b0, 8'd0,   8'd7}, // R7 absent
    '{1'b1, 8'h00, 8'h50, 8'h45, 9'd1,   8'd160, 9'd19, 1'b0, 8'd0,   8'd5}, // R5 half match
    '{1'b1, 8'h00, 8'h4E, 8'h50, 9'd1,   8'd160, 9'd19, 1'b0, 8'd0,   8'd5}, // R5 swapped
    '{1'b1, 8'h00, 8'h56, 8'h31, 9'd1,   8'd160, 9'd18, 1'b1, 8'd175, 8'd7}, // R7 exact fit
    '{1'b1, 8'h00, 8'h56, 8'h31, 9'd1,   8'd160, 9'd17, 1'b0, 8'd0,   8'd7}, // R7 one short
    '{1'b1, 8'h00, 8'h45, 8'h43, 9'd1,   8'd167, 9'd12, 1'b1, 8'd167, 8'd5}, // R5 mid start
    '{1'b1, 8'h00, 8'h50, 8'h4E, 9'd1,   8'd167, 9'd12, 1'b0, 8'd0,   8'd7}  // R7 before start
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [7:0]        wr_data_i = '0;
  logic              start_i = 1'b0;
  logic              mode_i = 1'b0;
  logic [7:0]        tag_i = '0, key0_i = '0, key1_i = '0;
  logic [ADDR_W:0]   buf_len_i = '0;
  logic [ADDR_W-1:0] rgn_start_i = '0;
  logic [ADDR_W:0]   rgn_len_i = '0;
  logic              done_o, found_o;
  logic [ADDR_W-1:0] offset_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  vpd_locator #(.ADDR_W(ADDR_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int a, input int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = ADDR_W'(a); wr_data_i = 8'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk_i);
    mode_i = v.mode; tag_i = v.tag; key0_i = v.k0; key1_i = v.k1;
    buf_len_i = v.blen; rgn_start_i = v.rs; rgn_len_i = v.rl;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk_i);
      n++;
    end
    ok = done_o;
  endtask

  task automatic run_vec(input vec_t v, input string req);
    bit ok;
    launch(v);
    wait_done(ok);
    chk(ok, {req, " done"}, int'(ok), 1);
    chk(found_o == v.ef, {req, " found"}, int'(found_o), int'(v.ef));
    if (v.ef) chk(offset_o == v.eo, {req, " offset"}, int'(offset_o), int'(v.eo));
  endtask

  function automatic vec_t tv(input logic [7:0] t, input logic ef, input logic [7:0] eo);
    return '{1'b0, t, 8'h00, 8'h00, 9'd256, 8'd0, 9'd0, ef, eo, 8'd3};
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit ok;
    int dones;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(done_o == 1'b0, "R9 reset done", int'(done_o), 0);
    chk(found_o == 1'b0, "R9 reset found", int'(found_o), 0);
    chk(offset_o == '0, "R9 reset offset", int'(offset_o), 0);
    rst_ni = 1'b1;

    for (int a = 0; a < 256; a++) put(a, 0);
    // tag chain: 0 -> 8 -> 27 -> 94 -> (353); 97 is a decoy
    put(0, 8'h82);  put(1, 8'h05);  put(2, 8'h00);
    put(8, 8'h90);  put(9, 8'h10);  put(10, 8'h00);
    put(27, 8'h91); put(28, 8'h40); put(29, 8'h00);
    put(94, 8'h84); put(95, 8'h00); put(96, 8'h01);
    put(97, 8'h85); put(98, 8'h00); put(99, 8'h00);
    put(100, 8'h78);
    // keyword region at 160
    put(160, 8'h50); put(161, 8'h4E); put(162, 8'h04);
    put(163, 8'h31); put(164, 8'h32); put(165, 8'h33); put(166, 8'h34);
    put(167, 8'h45); put(168, 8'h43); put(169, 8'h02);
    put(170, 8'h41); put(171, 8'h42);
    put(172, 8'h53); put(173, 8'h4E); put(174, 8'h00);
    put(175, 8'h56); put(176, 8'h31); put(177, 8'h01); put(178, 8'h5A);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i], $sformatf("vec%0d R%0d", i, VEC[i].req));
    end

    // R9 done lasts one cycle, result holds
    run_vec(VEC[2], "R9 base");
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9 done width", int'(done_o), 0);
    repeat (5) @(negedge clk_i);
    chk(found_o == 1'b1 && offset_o == 8'd27, "R9 held", int'(offset_o), 27);

    // R8 start during a running search
    launch(VEC[3]);
    @(negedge clk_i);
    mode_i = 1'b1; key0_i = 8'h50; key1_i = 8'h4E; rgn_start_i = 8'd160; rgn_len_i = 9'd19;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(ok);
    chk(ok && found_o && offset_o == 8'd94, "R8 result", int'(offset_o), 94);
    dones = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk_i);
      if (done_o) dones++;
    end
    chk(dones == 0, "R8 extra done", dones, 0);

    // R3 non-large byte ends the tag walk
    put(94, 8'h04);
    run_vec(tv(8'h84, 1'b0, 8'd0), "R3 stop");
    run_vec(tv(8'h04, 1'b0, 8'd0), "R3 equal small");
    run_vec(tv(8'h91, 1'b1, 8'd27), "R3 before stop");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule